// File: doc/BRIEF.md
# Hamming ECC Syndrome Decoder

This block checks a block of stored data against a 22-bit Hamming-style check code. The code has two 11-bit parity words, a parity word and its complement. The decoder takes the code that was computed while the data was read and the code that was stored beside the data. It XORs the two codes to form a syndrome and sorts the result into one of four classes:
- clean;
- a fault confined to the stored check bits;
- a single-bit data error that can be repaired;
- damage that cannot be repaired.

For a repairable error, the low 11 syndrome bits point straight at the bad bit. Bits 2:0 give the bit inside the byte and bits 10:3 give the byte inside the 256-byte block. The decoder then repairs the bit in place through a byte-wide read/modify/write port to the data buffer. The buffer has a read latency of one cycle.

In wide mode the decoder checks two 256-byte halves one after the other. Each half has its own code pair, and the second half is addressed 256 bytes above the first. Software or a sequencer starts a check with a one-cycle pulse and waits for a one-cycle completion pulse. The pulse comes with a 2-bit status that is held until the next check starts.

Top module: `ecc_syndrome_decoder`

## Requirements
- R1: After reset: `busy`, `done`, `mem_rd`, `mem_wr` and `fault` are 0; `status` is 00; `fix_byte` and `fix_bit` are 0.
- R2: A half gets status 00 (clean) and no buffer write in three cases: its syndrome is zero, its computed code is zero, or its stored code is zero.
- R3: A half whose syndrome has exactly one set bit gets status 01 (check-code fault). The buffer is not written.
- R4: A half is repairable, with status 10, when both of these hold:
  - exactly 11 syndrome bits are set;
  - syndrome[10:0] XOR syndrome[21:11] equals 0x7FF.

  For a repairable half, bit syndrome[2:0] of byte syndrome[10:3] is inverted in the buffer. `fix_byte` and `fix_bit` then report that location.
- R5: Any other nonzero syndrome gets status 11 (fatal). The buffer is not written.
- R6: In wide mode (`wide_mode`=1):
  - the first half uses code bits 21:0 and buffer addresses 0..255;
  - the second half uses code bits 43:22 and addresses 256..511;
  - `status` is the larger of the two half codes;
  - `fault` is 1 when either half is not clean.

  In narrow mode only the first half is checked.
- R7: A repair asserts `mem_rd` for one cycle at the failing address. It then asserts `mem_wr` in the next cycle at the same address, with `mem_wdata` equal to `mem_rdata` with the one bit inverted. The two strobes are never high together.
- R8: Let E be the clock edge that samples `start`. Let H be the number of halves checked and C the number of repairs. `done` is high for exactly one cycle, the cycle that follows edge E+2H+2C. `busy` is high from edge E until that cycle ends.
- R9: A `start` pulse while `busy` is high is ignored. It does not change the status, the timing or the buffer contents of the check in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse; codes and mode are sampled with it |
| wide_mode | input | 1 | 1: check two 256-byte halves, 0: one half |
| calc_codes | input | 44 | Computed codes; half 0 in 21:0, half 1 in 43:22 |
| stored_codes | input | 44 | Stored codes, same layout as `calc_codes` |
| busy | output | 1 | A check is in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 00 clean, 01 check-code fault, 10 repaired, 11 fatal |
| fault | output | 1 | At least one half was not clean |
| fix_byte | output | 9 | Buffer address of the last repaired byte |
| fix_bit | output | 3 | Bit index of the last repaired bit |
| mem_addr | output | 9 | Buffer byte address |
| mem_rd | output | 1 | Buffer read strobe, data returns one cycle later |
| mem_rdata | input | 8 | Buffer read data |
| mem_wr | output | 1 | Buffer write strobe |
| mem_wdata | output | 8 | Buffer write data |

## Verification
For each case the bench knows, from the syndrome classes alone, how long the check takes:
- every half adds two cycles, one to register the syndrome and its population count and one to classify it;
- every repair adds two more cycles, a read and a write;
- `done` follows on the next cycle.

Before each case the bench builds a queue of per-cycle events from these rules. It then steps through the queue one clock at a time from the edge that sampled `start`, sampling at the falling edge. On every cycle it compares `mem_rd`, `mem_wr`, `done` and `busy` against the queued event. One cycle after the completion pulse it checks the held status, the fault flag, the reported location and the whole buffer against its own model.

// File: rtl/ecc_dec_pkg.sv
package ecc_dec_pkg;

   // Severity-ordered: a larger code is a worse outcome.
   typedef enum logic [1:0] {
      ST_CLEAN    = 2'b00,
      ST_CODE_ERR = 2'b01,
      ST_FIXED    = 2'b10,
      ST_FATAL    = 2'b11
   } ecc_stat_e;

   typedef enum logic [2:0] {
      S_IDLE  = 3'd0,
      S_CHECK = 3'd1,
      S_CLASS = 3'd2,
      S_RD    = 3'd3,
      S_WR    = 3'd4,
      S_DONE  = 3'd5
   } dec_state_e;

endpackage

// File: rtl/ecc_syndrome_calc.sv
module ecc_syndrome_calc #(
   parameter int PAR_W     = 11,
   parameter int POP_STYLE = 1,
   localparam int CODE_W   = 2 * PAR_W,
   localparam int POP_W    = $clog2(CODE_W + 1)
) (
   input  logic [CODE_W-1:0] calc_code,
   input  logic [CODE_W-1:0] stored_code,
   output logic [CODE_W-1:0] syndrome,
   output logic [POP_W-1:0]  pop,
   output logic              trivial
);

   assign syndrome = calc_code ^ stored_code;
   assign trivial  = (syndrome == '0) || (calc_code == '0) || (stored_code == '0);

   generate
      if (POP_STYLE == 0) begin : g_pop_loop
         logic [POP_W-1:0] acc;
         always_comb begin
            acc = '0;
            for (int i = 0; i < CODE_W; i++) begin
               acc = acc + POP_W'(syndrome[i]);
            end
         end
         assign pop = acc;
      end else begin : g_pop_builtin
         assign pop = POP_W'($countones(syndrome));
      end
   endgenerate

endmodule

// File: rtl/ecc_classify.sv
module ecc_classify
   import ecc_dec_pkg::*;
#(
   parameter int PAR_W   = 11,
   localparam int CODE_W = 2 * PAR_W,
   localparam int POP_W  = $clog2(CODE_W + 1)
) (
   input  logic [CODE_W-1:0] syn,
   input  logic [POP_W-1:0]  pop,
   input  logic              trivial,
   output ecc_stat_e         stat
);

   logic pairs_ok;
   assign pairs_ok = ((syn[PAR_W-1:0] ^ syn[CODE_W-1:PAR_W]) == {PAR_W{1'b1}});

   always_comb begin
      if (trivial)
         stat = ST_CLEAN;
      else if (pop == POP_W'(1))
         stat = ST_CODE_ERR;
      else if (pop == POP_W'(PAR_W) && pairs_ok)
         stat = ST_FIXED;
      else
         stat = ST_FATAL;
   end

endmodule

// File: rtl/ecc_bit_fix.sv
module ecc_bit_fix (
   input  logic [7:0] rdata,
   input  logic [2:0] bit_idx,
   output logic [7:0] wdata
);

   assign wdata = rdata ^ (8'd1 << bit_idx);

endmodule

// File: rtl/ecc_syndrome_decoder.sv
module ecc_syndrome_decoder
   import ecc_dec_pkg::*;
#(
   parameter int PAR_W     = 11,
   parameter int POP_STYLE = 1,
   localparam int CODE_W   = 2 * PAR_W,
   localparam int IDX_W    = PAR_W - 3,
   localparam int ADDR_W   = IDX_W + 1,
   localparam int POP_W    = $clog2(CODE_W + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                wide_mode,
   input  logic [2*CODE_W-1:0] calc_codes,
   input  logic [2*CODE_W-1:0] stored_codes,
   output logic                busy,
   output logic                done,
   output logic [1:0]          status,
   output logic                fault,
   output logic [ADDR_W-1:0]   fix_byte,
   output logic [2:0]          fix_bit,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic                mem_rd,
   input  logic [7:0]          mem_rdata,
   output logic                mem_wr,
   output logic [7:0]          mem_wdata
);

   generate
      if (PAR_W < 4) begin : g_bad_par_w
         $error("PAR_W must leave at least one byte-index bit above the 3 bit-index bits");
      end
      if (POP_STYLE != 0 && POP_STYLE != 1) begin : g_bad_pop_style
         $error("POP_STYLE must be 0 or 1");
      end
   endgenerate

   dec_state_e state_q;
   logic [2*CODE_W-1:0] calc_q, stored_q;
   logic wide_q, half_q;
   logic [CODE_W-1:0] syn_q;
   logic [POP_W-1:0] pop_q;
   logic trivial_q;
   ecc_stat_e worst_q;
   logic fault_q;
   logic [ADDR_W-1:0] addr_q;
   logic [2:0] bit_q;

   logic [CODE_W-1:0] cur_calc, cur_stored, syn_d;
   logic [POP_W-1:0] pop_d;
   logic trivial_d;
   ecc_stat_e cls_stat;
   logic more_halves;

   assign cur_calc    = half_q ? calc_q[CODE_W +: CODE_W]   : calc_q[0 +: CODE_W];
   assign cur_stored  = half_q ? stored_q[CODE_W +: CODE_W] : stored_q[0 +: CODE_W];
   assign more_halves = wide_q && !half_q;

   ecc_syndrome_calc #(.PAR_W(PAR_W), .POP_STYLE(POP_STYLE)) u_calc (
      .calc_code   (cur_calc),
      .stored_code (cur_stored),
      .syndrome    (syn_d),
      .pop         (pop_d),
      .trivial     (trivial_d)
   );

   ecc_classify #(.PAR_W(PAR_W)) u_class (
      .syn     (syn_q),
      .pop     (pop_q),
      .trivial (trivial_q),
      .stat    (cls_stat)
   );

   ecc_bit_fix u_fix (
      .rdata   (mem_rdata),
      .bit_idx (bit_q),
      .wdata   (mem_wdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= S_IDLE;
         calc_q    <= '0;
         stored_q  <= '0;
         wide_q    <= 1'b0;
         half_q    <= 1'b0;
         syn_q     <= '0;
         pop_q     <= '0;
         trivial_q <= 1'b0;
         worst_q   <= ST_CLEAN;
         fault_q   <= 1'b0;
         addr_q    <= '0;
         bit_q     <= '0;
      end else begin
         case (state_q)
            S_IDLE: begin
               if (start) begin
                  calc_q   <= calc_codes;
                  stored_q <= stored_codes;
                  wide_q   <= wide_mode;
                  half_q   <= 1'b0;
                  worst_q  <= ST_CLEAN;
                  fault_q  <= 1'b0;
                  addr_q   <= '0;
                  bit_q    <= '0;
                  state_q  <= S_CHECK;
               end
            end
            S_CHECK: begin
               syn_q     <= syn_d;
               pop_q     <= pop_d;
               trivial_q <= trivial_d;
               state_q   <= S_CLASS;
            end
            S_CLASS: begin
               if (cls_stat > worst_q) worst_q <= cls_stat;
               if (cls_stat != ST_CLEAN) fault_q <= 1'b1;
               if (cls_stat == ST_FIXED) begin
                  addr_q  <= {half_q, syn_q[PAR_W-1:3]};
                  bit_q   <= syn_q[2:0];
                  state_q <= S_RD;
               end else if (more_halves) begin
                  half_q  <= 1'b1;
                  state_q <= S_CHECK;
               end else begin
                  state_q <= S_DONE;
               end
            end
            S_RD: state_q <= S_WR;
            S_WR: begin
               if (more_halves) begin
                  half_q  <= 1'b1;
                  state_q <= S_CHECK;
               end else begin
                  state_q <= S_DONE;
               end
            end
            S_DONE:  state_q <= S_IDLE;
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign busy     = (state_q != S_IDLE);
   assign done     = (state_q == S_DONE);
   assign mem_rd   = (state_q == S_RD);
   assign mem_wr   = (state_q == S_WR);
   assign mem_addr = addr_q;
   assign fix_byte = addr_q;
   assign fix_bit  = bit_q;
   assign status   = worst_q;
   assign fault    = fault_q;

   // R7: write strobe only in the cycle after a read strobe, same address
   p_wr_follows_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> ($past(mem_rd) && mem_addr == $past(mem_addr)));
   p_rd_then_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> mem_wr);
   p_strobes_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));
   // R4: write-back differs from the read byte in exactly one bit
   p_one_bit_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> ($countones(mem_wdata ^ mem_rdata) == 1));
   // R4: a repair is only started for an 11-bit syndrome
   p_repair_weight_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> (pop_q == POP_W'(PAR_W)));
   // R8: completion is a single-cycle pulse followed by idle
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));
   // R6: the second half is only visited in wide mode
   p_half_only_wide_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(half_q) |-> wide_q);
   // R2: a clean outcome never carries a fault flag at completion
   p_clean_no_fault_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (done && status == 2'b00) |-> !fault);

endmodule

// File: tb/ecc_syndrome_decoder_test.sv
module ecc_syndrome_decoder_test;

   localparam int CLK_PERIOD = 10;
   localparam int CW = 22;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic wide_mode = 1'b0;
   logic [2*CW-1:0] calc_codes = '0;
   logic [2*CW-1:0] stored_codes = '0;
   logic busy, done, fault, mem_rd, mem_wr;
   logic [1:0] status;
   logic [8:0] fix_byte, mem_addr;
   logic [2:0] fix_bit;
   logic [7:0] mem_rdata, mem_wdata;

   int total = 0;
   int bad = 0;
   int cycles = 0;

   logic [7:0] mem [512];
   logic [7:0] ref_mem [512];

   always #(CLK_PERIOD/2) clk = ~clk;

   ecc_syndrome_decoder uut (
      .clk(clk), .rst_n(rst_n), .start(start), .wide_mode(wide_mode),
      .calc_codes(calc_codes), .stored_codes(stored_codes),
      .busy(busy), .done(done), .status(status), .fault(fault),
      .fix_byte(fix_byte), .fix_bit(fix_bit),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
      .mem_wr(mem_wr), .mem_wdata(mem_wdata)
   );

   // Buffer model: one cycle read latency
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 512; i++) mem[i] <= 8'((i * 7 + 3) & 255);
         mem_rdata <= 8'h00;
      end else begin
         if (mem_rd) mem_rdata <= mem[mem_addr];
         if (mem_wr) mem[mem_addr] <= mem_wdata;
      end
   end

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 100000) begin
         bad = bad + 1;
         total = total + 1;
         $display("FAIL watchdog: run hung, actual=%0d cycles expected<100000", cycles);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total = total + 1;
      if (!ok) begin
         bad = bad + 1;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [1:0] half_stat(input logic [CW-1:0] c, input logic [CW-1:0] s);
      logic [CW-1:0] syn;
      int n;
      syn = c ^ s;
      n = $countones(syn);
      if (syn == 0 || c == 0 || s == 0) return 2'd0;
      if (n == 1) return 2'd1;
      if (n == 11 && (syn[10:0] ^ syn[21:11]) == 11'h7FF) return 2'd2;
      return 2'd3;
   endfunction

   function automatic logic [CW-1:0] mk_syn(input int byte_i, input int bit_i);
      logic [10:0] loc;
      loc = 11'((byte_i << 3) | bit_i);
      return {~loc, loc};
   endfunction

   task automatic run_case(input string tag, input bit wide,
                           input logic [2*CW-1:0] c, input logic [2*CW-1:0] s,
                           input bit glitch);
      int q[$];
      int nh;
      logic [1:0] worst, st;
      bit exp_fault;
      int exp_byte, exp_bit, mism;
      logic [CW-1:0] syn;
      int ev;
      nh = wide ? 2 : 1;
      worst = 0; exp_fault = 0; exp_byte = 0; exp_bit = 0;
      for (int h = 0; h < nh; h++) begin
         st = half_stat(c[h*CW +: CW], s[h*CW +: CW]);
         syn = c[h*CW +: CW] ^ s[h*CW +: CW];
         if (st > worst) worst = st;
         if (st != 0) exp_fault = 1;
         q.push_back(0); q.push_back(0);
         if (st == 2) begin
            exp_byte = h * 256 + int'(syn[10:3]);
            exp_bit  = int'(syn[2:0]);
            ref_mem[exp_byte][exp_bit] = ~ref_mem[exp_byte][exp_bit];
            q.push_back(1); q.push_back(exp_byte * 16 + 2);
         end
      end
      q.push_back(3);

      @(negedge clk);
      start = 1'b1; wide_mode = wide; calc_codes = c; stored_codes = s;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      for (int n = 0; n < q.size(); n++) begin
         if (n >= 2) start = 1'b0;
         ev = q[n];
         chk(mem_rd == (ev == 1), {tag, " R7 rd strobe"}, int'(mem_rd), int'(ev == 1));
         chk(mem_wr == ((ev & 15) == 2), {tag, " R7 wr strobe"}, int'(mem_wr), int'((ev & 15) == 2));
         if ((ev & 15) == 2)
            chk(int'(mem_addr) == (ev >> 4), {tag, " R7 wr addr"}, int'(mem_addr), ev >> 4);
         chk(done == (ev == 3), {tag, " R8 done timing"}, int'(done), int'(ev == 3));
         chk(busy == 1'b1, {tag, " R8 busy"}, int'(busy), 1);
         if (glitch && n == 1) begin
            start = 1'b1; wide_mode = 1'b1;
            calc_codes = {22'h000003, 22'h000003}; stored_codes = '0 | 44'h3FFFFF;
         end
         @(posedge clk);
         @(negedge clk);
      end
      start = 1'b0;
      chk(busy == 1'b0 && done == 1'b0, {tag, " R8 idle after done"}, int'({busy, done}), 0);
      chk(status == worst, {tag, " status"}, int'(status), int'(worst));
      chk(fault == exp_fault, {tag, " R6 fault"}, int'(fault), int'(exp_fault));
      chk(int'(fix_byte) == exp_byte && int'(fix_bit) == exp_bit, {tag, " R4 location"},
          int'({fix_byte, fix_bit}), exp_byte * 8 + exp_bit);
      mism = 0;
      for (int i = 0; i < 512; i++) if (mem[i] !== ref_mem[i]) mism++;
      chk(mism == 0, {tag, " buffer contents"}, mism, 0);
   endtask

   initial begin
      for (int i = 0; i < 512; i++) ref_mem[i] = 8'((i * 7 + 3) & 255);
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      chk(!busy && !done && !mem_rd && !mem_wr && !fault && status == 2'b00,
          "R1 reset outputs", int'({busy, done, mem_rd, mem_wr, fault, status}), 0);
      chk(fix_byte == 0 && fix_bit == 0, "R1 reset location", int'({fix_byte, fix_bit}), 0);
      rst_n = 1'b1;
      repeat (2) @(posedge clk);

      run_case("R2 equal codes", 0, {22'h0, 22'h123456}, {22'h0, 22'h123456}, 0);
      run_case("R2 calc zero", 0, {22'h0, 22'h000000}, {22'h0, 22'h0000FF}, 0);
      run_case("R2 stored zero", 0, {22'h0, 22'h00ABCD}, {22'h0, 22'h000000}, 0);
      run_case("R3 one bit", 0, {22'h0, 22'h155555 ^ 22'h000400}, {22'h0, 22'h155555}, 0);
      run_case("R4 mid location", 0, {22'h0, 22'h0ABCDE ^ mk_syn(8'h2A, 5)}, {22'h0, 22'h0ABCDE}, 0);
      run_case("R4 top location", 0, {22'h0, 22'h0ABCDE ^ mk_syn(255, 7)}, {22'h0, 22'h0ABCDE}, 0);
      run_case("R4 zero location", 0, {22'h0, 22'h2F0F0F ^ mk_syn(0, 0)}, {22'h0, 22'h2F0F0F}, 0);
      run_case("R5 two bits", 0, {22'h0, 22'h0F0F0F ^ 22'h000003}, {22'h0, 22'h0F0F0F}, 0);
      run_case("R5 eleven unpaired", 0, {22'h0, 22'h0F0F0F ^ 22'h0013FF}, {22'h0, 22'h0F0F0F}, 0);
      run_case("R6 narrow ignores upper",
               0, {22'h0F0F0F ^ 22'h000003, 22'h111111}, {22'h0F0F0F, 22'h111111}, 0);
      run_case("R6 upper repair",
               1, {22'h0ABCDE ^ mk_syn(8'hF3, 2), 22'h111111}, {22'h0ABCDE, 22'h111111}, 0);
      run_case("R6 repair then fatal",
               1, {22'h0F0F0F ^ 22'h000003, 22'h0ABCDE ^ mk_syn(9, 6)}, {22'h0F0F0F, 22'h0ABCDE}, 0);
      run_case("R6 code fault lower",
               1, {22'h222222, 22'h155555 ^ 22'h200000}, {22'h222222, 22'h155555}, 0);
      run_case("R9 start while busy",
               0, {22'h0, 22'h0ABCDE ^ mk_syn(77, 1)}, {22'h0, 22'h0ABCDE}, 1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule